// File: doc/BRIEF.md
# Control Endpoint Prime Tracker and Handshake Selector

This block keeps the prime state of one bidirectional device control endpoint and chooses the handshake returned for every token the endpoint receives. The endpoint has a receive direction (host-to-device, OUT tokens) and a transmit direction (device-to-host, IN tokens). Software asks for a direction to be primed by pulsing a request bit. The block then shows a busy prime bit for a fixed number of cycles. When that bit drops, it either raises the direction's ready bit with a one-cycle success pulse, or leaves ready low with a one-cycle failure pulse.

A prime fails when the descriptor reported on the sideband is not valid, when its packets-per-frame multiplier is nonzero (a control endpoint allows no high-bandwidth multiplier), or when a SETUP token arrives while the prime is in progress. Each SETUP clears the ready bit of both directions and raises a sticky setup-pending flag. As a result, a stage that was primed before the new SETUP cannot carry on with stale data. While the flag is set, new prime requests are refused. Software clears the flag by writing one to it.

Tokens come in on a sideband with a type, a last-packet marker and a receive-room indication. The handshake comes out one cycle later. A data or status stage is primed the same way: a zero-length status transfer is just a prime with a valid descriptor.

Top module: `ctl_ep_handshake`

## Requirements
- R1: A request on `prime_req[d]`, made while `prime_busy[d]` is low and no setup is pending, raises `prime_busy[d]` at the next edge. The bit stays high for exactly PRIME_LAT cycles and then clears. A request made while busy is ignored.
- R2: When the prime completes with `desc_valid`=1, `desc_mult`=0 and no SETUP seen during the prime, `ready[d]` becomes 1 and `prime_ok[d]` pulses for one cycle, in the same cycle that `prime_busy[d]` clears.
- R3: When the prime completes with `desc_valid`=0 or a nonzero `desc_mult`, `ready[d]` stays 0 and `prime_fail[d]` pulses for one cycle instead of `prime_ok[d]`.
- R4: A SETUP token accepted while `prime_busy[d]` is high makes that prime end with `prime_fail[d]`.
- R5: A SETUP token (`tok_type`=2'b00) clears `ready[0]` and `ready[1]` at the next edge.
- R6: A SETUP token sets `setup_pend` at the next edge. `setup_clr`=1 clears it. When both happen in the same cycle, the flag ends up set.
- R7: While `setup_pend` is 1, a prime request is ignored: `prime_busy` stays 0 and no `prime_ok` or `prime_fail` pulse follows.
- R8: Every token of type SETUP (2'b00), OUT (2'b01) or IN (2'b10) produces `hs_valid`=1 with a code on `hs_code` one cycle later. Type 2'b11 produces none. The codes are ACK=0, NAK=1, NYET=2, STALL=3, DATA=4. A SETUP always gets ACK, even while `stall` is 1.
- R9: While `stall` is 1, OUT and IN tokens get STALL.
- R10: With `stall`=0, an OUT token gets NAK when `ready[0]`=0, and an IN token gets NAK when `ready[1]`=0.
- R11: With `stall`=0 and `ready[0]`=1, an OUT token gets ACK when `out_room`=1 and NYET when `out_room`=0. With `ready[1]`=1, an IN token gets DATA.
- R12: An OUT token accepted with `tok_last`=1 clears `ready[0]` at the same edge that registers its handshake. An IN token answered with DATA and `tok_last`=1 clears `ready[1]` in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prime_req | input | 2 | Prime request pulse per direction (0 receive, 1 transmit) |
| desc_valid | input | 1 | Descriptor for the prime being completed is well formed |
| desc_mult | input | MULT_W | Packets-per-frame multiplier of that descriptor |
| setup_clr | input | 1 | Write-one-to-clear for the setup-pending flag |
| stall | input | 1 | Endpoint stalled |
| tok_valid | input | 1 | Token strobe |
| tok_type | input | 2 | 00 SETUP, 01 OUT, 10 IN, 11 ignored |
| tok_last | input | 1 | Packet ends the primed transfer |
| out_room | input | 1 | Receive buffer can take another packet |
| prime_busy | output | 2 | Prime in progress per direction |
| ready | output | 2 | Direction primed and ready |
| prime_ok | output | 2 | One-cycle prime success pulse |
| prime_fail | output | 2 | One-cycle prime failure pulse |
| setup_pend | output | 1 | Sticky SETUP-received flag |
| hs_valid | output | 1 | Handshake strobe |
| hs_code | output | 3 | Handshake code |

## Verification
The bench builds the block with PRIME_LAT=3 and MULT_W=2. This makes the prime window short enough to count edge by edge, and all four multiplier values can be tried. For every combination of the two ready bits, it sweeps both stall levels, both data token types and both receive-room levels. It compares each handshake against a table the bench derives itself. It also places a SETUP inside a running prime and sends SETUP and flag-clear in the same cycle.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;

  typedef enum logic [1:0] {
    TOK_SETUP = 2'd0,
    TOK_OUT   = 2'd1,
    TOK_IN    = 2'd2,
    TOK_RSVD  = 2'd3
  } tok_e;

  typedef enum logic [2:0] {
    HS_ACK   = 3'd0,
    HS_NAK   = 3'd1,
    HS_NYET  = 3'd2,
    HS_STALL = 3'd3,
    HS_DATA  = 3'd4
  } hs_e;

  localparam int DIR_RX = 0;
  localparam int DIR_TX = 1;
  localparam int NUM_DIR = 2;

  // A descriptor may be used only if it is valid and carries no multiplier.
  function automatic logic desc_usable(input logic valid, input logic mult_nonzero);
    return valid && !mult_nonzero;
  endfunction

  // Handshake for one token given the endpoint state.
  function automatic hs_e pick_hs(input logic [1:0] tok, input logic stalled,
                                  input logic rx_rdy, input logic tx_rdy,
                                  input logic room);
    hs_e r;
    r = HS_NAK;
    unique case (tok)
      TOK_SETUP: r = HS_ACK;
      TOK_OUT: begin
        if (stalled)     r = HS_STALL;
        else if (!rx_rdy) r = HS_NAK;
        else if (room)   r = HS_ACK;
        else             r = HS_NYET;
      end
      TOK_IN: begin
        if (stalled)     r = HS_STALL;
        else if (!tx_rdy) r = HS_NAK;
        else             r = HS_DATA;
      end
      default: r = HS_NAK;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ctl_prime_track.sv
module ctl_prime_track #(
  parameter int PRIME_LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic setup_seen,
  input  logic desc_ok,
  input  logic consume,
  output logic busy,
  output logic ready,
  output logic done_ok,
  output logic done_fail
);
  localparam int CNT_W = (PRIME_LAT > 1) ? $clog2(PRIME_LAT) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PRIME_LAT - 1);

  logic [CNT_W-1:0] cnt;
  logic             aborted;
  logic             finish;
  logic             verdict;

  assign finish  = busy && (cnt == '0);
  assign verdict = desc_ok && !aborted && !setup_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      aborted   <= 1'b0;
      done_ok   <= 1'b0;
      done_fail <= 1'b0;
    end else begin
      done_ok   <= 1'b0;
      done_fail <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          cnt     <= CNT_LOAD;
          aborted <= setup_seen;
        end
      end else begin
        if (setup_seen) aborted <= 1'b1;
        if (finish) begin
          busy      <= 1'b0;
          done_ok   <= verdict;
          done_fail <= !verdict;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          ready <= 1'b0;
    else if (setup_seen) ready <= 1'b0;
    else if (finish)     ready <= verdict;
    else if (consume)    ready <= 1'b0;
  end

endmodule

// File: rtl/ctl_hs_select.sv
module ctl_hs_select
  import ctl_ep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tok_valid,
  input  logic [1:0] tok_type,
  input  logic       tok_last,
  input  logic       stall,
  input  logic       out_room,
  input  logic [1:0] ready,
  output logic [1:0] consume,
  output logic       hs_valid,
  output logic [2:0] hs_code
);
  logic tok_known;
  hs_e  hs_next;

  assign tok_known = tok_valid && (tok_type != TOK_RSVD);
  assign hs_next   = pick_hs(tok_type, stall, ready[DIR_RX], ready[DIR_TX], out_room);

  assign consume[DIR_RX] = tok_valid && (tok_type == TOK_OUT) && !stall &&
                           ready[DIR_RX] && tok_last;
  assign consume[DIR_TX] = tok_valid && (tok_type == TOK_IN) && !stall &&
                           ready[DIR_TX] && tok_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_valid <= 1'b0;
      hs_code  <= HS_ACK;
    end else begin
      hs_valid <= tok_known;
      if (tok_known) hs_code <= hs_next;
    end
  end

endmodule

// File: rtl/ctl_ep_handshake.sv
module ctl_ep_handshake
  import ctl_ep_pkg::*;
#(
  parameter int PRIME_LAT = 4,
  parameter int MULT_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        prime_req,
  input  logic              desc_valid,
  input  logic [MULT_W-1:0] desc_mult,
  input  logic              setup_clr,
  input  logic              stall,
  input  logic              tok_valid,
  input  logic [1:0]        tok_type,
  input  logic              tok_last,
  input  logic              out_room,
  output logic [1:0]        prime_busy,
  output logic [1:0]        ready,
  output logic [1:0]        prime_ok,
  output logic [1:0]        prime_fail,
  output logic              setup_pend,
  output logic              hs_valid,
  output logic [2:0]        hs_code
);
  // Named internal events, also used by the checker.
  logic       setup_now;
  logic [1:0] start;
  logic [1:0] consume;
  logic       desc_ok;

  assign setup_now = tok_valid && (tok_type == TOK_SETUP);
  assign desc_ok   = desc_usable(desc_valid, |desc_mult);

  always_ff @(posedge clk) begin
    if (!rst_n)         setup_pend <= 1'b0;
    else if (setup_now) setup_pend <= 1'b1;
    else if (setup_clr) setup_pend <= 1'b0;
  end

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    assign start[d] = prime_req[d] && !setup_pend;

    ctl_prime_track #(.PRIME_LAT(PRIME_LAT)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start[d]),
      .setup_seen(setup_now),
      .desc_ok   (desc_ok),
      .consume   (consume[d]),
      .busy      (prime_busy[d]),
      .ready     (ready[d]),
      .done_ok   (prime_ok[d]),
      .done_fail (prime_fail[d])
    );
  end

  ctl_hs_select u_hs (
    .clk      (clk),
    .rst_n    (rst_n),
    .tok_valid(tok_valid),
    .tok_type (tok_type),
    .tok_last (tok_last),
    .stall    (stall),
    .out_room (out_room),
    .ready    (ready),
    .consume  (consume),
    .hs_valid (hs_valid),
    .hs_code  (hs_code)
  );

endmodule

// File: rtl/ctl_ep_handshake_chk.sv
module ctl_ep_handshake_chk
  import ctl_ep_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] prime_req,
  input logic       stall,
  input logic       tok_valid,
  input logic [1:0] tok_type,
  input logic [1:0] prime_busy,
  input logic [1:0] ready,
  input logic [1:0] prime_ok,
  input logic [1:0] prime_fail,
  input logic       setup_pend,
  input logic       hs_valid,
  input logic [2:0] hs_code,
  input logic       setup_now
);

  // R2 / R3: every falling busy bit is reported as success or failure
  a_r2_rx_done_reported: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prime_busy[0]) |-> (prime_ok[0] || prime_fail[0]));
  a_r2_tx_done_reported: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prime_busy[1]) |-> (prime_ok[1] || prime_fail[1]));

  // R3: a failed prime never leaves the direction ready
  a_r3_fail_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (prime_fail != 2'b00) |-> ((ready & prime_fail) == 2'b00));

  // R5 / R6: SETUP clears readiness and raises the pending flag
  a_r5_setup_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
    setup_now |=> (ready == 2'b00 && setup_pend));

  // R7: prime requests are refused while a setup is pending
  a_r7_reject_when_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (prime_req[0] && setup_pend && !prime_busy[0]) |=> !prime_busy[0]);

  // R8: SETUP always acknowledged
  a_r8_setup_ack: assert property (@(posedge clk) disable iff (!rst_n)
    setup_now |=> (hs_valid && hs_code == HS_ACK));

  // R9: stalled data tokens get STALL
  a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && stall && (tok_type == TOK_OUT || tok_type == TOK_IN))
      |=> (hs_valid && hs_code == HS_STALL));

  // R10: OUT to an unready receive direction gets NAK
  a_r10_out_nak: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && !stall && tok_type == TOK_OUT && !ready[0])
      |=> (hs_valid && hs_code == HS_NAK));

endmodule

bind ctl_ep_handshake ctl_ep_handshake_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .prime_req (prime_req),
  .stall     (stall),
  .tok_valid (tok_valid),
  .tok_type  (tok_type),
  .prime_busy(prime_busy),
  .ready     (ready),
  .prime_ok  (prime_ok),
  .prime_fail(prime_fail),
  .setup_pend(setup_pend),
  .hs_valid  (hs_valid),
  .hs_code   (hs_code),
  .setup_now (setup_now)
);

// File: tb/ctl_ep_handshake_test.sv
module ctl_ep_handshake_test;
  localparam int LAT = 3;
  localparam int MW  = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    prime_req = '0;
  logic          desc_valid = 1'b1;
  logic [MW-1:0] desc_mult = '0;
  logic          setup_clr = 1'b0;
  logic          stall = 1'b0;
  logic          tok_valid = 1'b0;
  logic [1:0]    tok_type = 2'd0;
  logic          tok_last = 1'b0;
  logic          out_room = 1'b0;
  logic [1:0]    prime_busy, ready, prime_ok, prime_fail;
  logic          setup_pend, hs_valid;
  logic [2:0]    hs_code;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ctl_ep_handshake #(.PRIME_LAT(LAT), .MULT_W(MW)) uut (
    .clk(clk), .rst_n(rst_n), .prime_req(prime_req), .desc_valid(desc_valid),
    .desc_mult(desc_mult), .setup_clr(setup_clr), .stall(stall),
    .tok_valid(tok_valid), .tok_type(tok_type), .tok_last(tok_last),
    .out_room(out_room), .prime_busy(prime_busy), .ready(ready),
    .prime_ok(prime_ok), .prime_fail(prime_fail), .setup_pend(setup_pend),
    .hs_valid(hs_valid), .hs_code(hs_code)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected handshake from the requirement table (R8..R11).
  function automatic int want_hs(int tok, bit st, bit rr, bit tr, bit room);
    if (tok == 0) return 0;
    if (st) return 3;
    if (tok == 1) begin
      if (!rr) return 1;
      return room ? 0 : 2;
    end
    return tr ? 4 : 1;
  endfunction

  // Send one token; sample the handshake one cycle later.
  task automatic send_tok(input int tok, input bit last, input int exp, input string req);
    tok_valid = 1'b1; tok_type = 2'(tok); tok_last = last;
    @(negedge clk);
    tok_valid = 1'b0; tok_last = 1'b0;
    check(hs_valid == (tok != 3), req, int'(hs_valid), int'(tok != 3));
    if (tok != 3) check(int'(hs_code) == exp, req, int'(hs_code), exp);
  endtask

  task automatic clear_pend();
    setup_clr = 1'b1;
    @(negedge clk);
    setup_clr = 1'b0;
    check(setup_pend == 1'b0, "R6 clear", int'(setup_pend), 0);
  endtask

  // Run one prime on direction d and check the busy window and outcome.
  task automatic do_prime(input int d, input bit valid, input int mult,
                          input bit inject_setup, input bit exp_ok, input string req);
    prime_req[d] = 1'b1; desc_valid = valid; desc_mult = MW'(mult);
    @(negedge clk);
    prime_req[d] = 1'b0;
    check(prime_busy[d] == 1'b1, "R1 busy", int'(prime_busy[d]), 1);
    if (inject_setup) begin tok_valid = 1'b1; tok_type = 2'd0; end
    for (int k = 2; k <= LAT; k++) begin
      @(negedge clk);
      tok_valid = 1'b0;
      check(prime_busy[d] == 1'b1, "R1 window", int'(prime_busy[d]), 1);
    end
    @(negedge clk);
    check(prime_busy[d] == 1'b0, "R1 end", int'(prime_busy[d]), 0);
    check(prime_ok[d] == exp_ok, req, int'(prime_ok[d]), int'(exp_ok));
    check(prime_fail[d] == !exp_ok, req, int'(prime_fail[d]), int'(!exp_ok));
    check(ready[d] == exp_ok, req, int'(ready[d]), int'(exp_ok));
    @(negedge clk);
    check(prime_ok[d] == 1'b0 && prime_fail[d] == 1'b0, "R2 pulse width",
          int'(prime_ok[d] | prime_fail[d]), 0);
    desc_valid = 1'b1; desc_mult = '0;
    if (inject_setup) clear_pend();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(prime_busy == 2'b00 && ready == 2'b00 && setup_pend == 1'b0 && hs_valid == 1'b0,
          "reset", int'({prime_busy, ready, setup_pend, hs_valid}), 0);

    // R2 success on each direction, R3 failures, R4 aborted prime
    for (int d = 0; d < 2; d++) begin
      do_prime(d, 1'b1, 0, 1'b0, 1'b1, "R2 success");
      do_prime(d, 1'b0, 0, 1'b0, 1'b0, "R3 invalid descriptor");
      for (int m = 1; m < 4; m++) do_prime(d, 1'b1, m, 1'b0, 1'b0, "R3 nonzero multiplier");
      do_prime(d, 1'b1, 0, 1'b1, 1'b0, "R4 setup during prime");
    end

    // R1 request while busy is ignored: window still ends after LAT cycles
    prime_req[0] = 1'b1;
    @(negedge clk);
    check(prime_busy[0] == 1'b1, "R1 start", int'(prime_busy[0]), 1);
    for (int k = 2; k <= LAT; k++) @(negedge clk);
    prime_req[0] = 1'b0;
    @(negedge clk);
    check(prime_busy[0] == 1'b0 && prime_ok[0] == 1'b1, "R1 rerequest ignored",
          int'({prime_busy[0], prime_ok[0]}), 1);
    @(negedge clk);

    // R5 / R6: setup clears both ready bits and sets pending
    do_prime(1, 1'b1, 0, 1'b0, 1'b1, "R2 success tx");
    check(ready == 2'b11, "R2 both ready", int'(ready), 3);
    send_tok(0, 1'b0, 0, "R8 setup ack");
    check(ready == 2'b00, "R5 ready cleared", int'(ready), 0);
    check(setup_pend == 1'b1, "R6 pending set", int'(setup_pend), 1);

    // R7: prime refused while pending
    prime_req = 2'b11;
    @(negedge clk);
    prime_req = 2'b00;
    check(prime_busy == 2'b00, "R7 refused", int'(prime_busy), 0);
    for (int k = 0; k <= LAT; k++) begin
      @(negedge clk);
      check(prime_ok == 2'b00 && prime_fail == 2'b00 && prime_busy == 2'b00,
            "R7 no outcome", int'({prime_ok, prime_fail}), 0);
    end
    clear_pend();

    // R6: setup and clear in the same cycle, set wins
    setup_clr = 1'b1;
    send_tok(0, 1'b0, 0, "R8 setup ack");
    setup_clr = 1'b0;
    check(setup_pend == 1'b1, "R6 set wins", int'(setup_pend), 1);
    clear_pend();

    // R8 reserved token type produces no handshake
    send_tok(3, 1'b0, 0, "R8 reserved ignored");

    // R8..R11 sweep over ready states, stall, token type and room
    for (int rs = 0; rs < 4; rs++) begin
      send_tok(0, 1'b0, 0, "R5 clear before sweep");
      clear_pend();
      if (rs[0]) do_prime(0, 1'b1, 0, 1'b0, 1'b1, "R2 sweep prime rx");
      if (rs[1]) do_prime(1, 1'b1, 0, 1'b0, 1'b1, "R2 sweep prime tx");
      for (int st = 0; st < 2; st++)
        for (int tk = 1; tk < 3; tk++)
          for (int rm = 0; rm < 2; rm++) begin
            stall = st[0]; out_room = rm[0];
            send_tok(tk, 1'b0, want_hs(tk, st[0], rs[0], rs[1], rm[0]),
                     st[0] ? "R9 stall" : (rs == 0 ? "R10 nak" : "R11 primed"));
          end
      stall = 1'b1;
      send_tok(0, 1'b0, 0, "R8 setup ack while stalled");
      stall = 1'b0;
      clear_pend();
    end

    // R12: last packet consumes readiness
    do_prime(0, 1'b1, 0, 1'b0, 1'b1, "R2 prime rx");
    do_prime(1, 1'b1, 0, 1'b0, 1'b1, "R2 prime tx");
    out_room = 1'b1;
    send_tok(1, 1'b1, 0, "R12 last OUT ack");
    check(ready == 2'b10, "R12 rx consumed", int'(ready), 2);
    send_tok(1, 1'b0, 1, "R12 OUT after consume nak");
    send_tok(2, 1'b1, 4, "R12 last IN data");
    check(ready == 2'b00, "R12 tx consumed", int'(ready), 0);
    send_tok(2, 1'b0, 1, "R12 IN after consume nak");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule